// File: doc/BRIEF.md
# Floating-Point Issue Scoreboard

This block decides, cycle by cycle, whether a floating-point operation presented at the issue point may start. The unit it guards has two execution resources. One is a shared pipelined path that runs adds, multiplies and fused multiply-adds. The other is a single iterative engine that runs divides, reciprocals, square roots and reciprocal square roots, and it is not pipelined. Each operation class has its own result latency and issue interval, and both values depend on the precision. Single-precision pipelined operations can start every cycle. A double-precision multiply holds the pipelined path for two cycles. An iterative operation keeps the engine busy for all but the last two cycles of its latency.

The scoreboard keeps one down-counter for each resource and one ready counter for each destination register. A request is granted when four conditions hold: its execution resource is free, neither source register has a result outstanding, its own result would land strictly after any older write to the same destination, and no flush is being applied. Otherwise the request is stalled and must be held by the issuer. A flush drops all outstanding timing state in a single cycle.

Top module: `fp_issue_scoreboard`

## Requirements
- R1: Synchronous active-high `rst` clears all timing state. In the first cycle after reset, a valid request is granted whatever its registers or class.
- R2: `issue_grant` is high only when `req_valid` is high and no hazard exists. `issue_stall` equals `req_valid` and not `issue_grant`. Both are low when `req_valid` is low.
- R3: Single-precision add, multiply and multiply-add, and double-precision add, have a result latency of 4 cycles. They may be granted on consecutive cycles.
- R4: Double-precision multiply (`req_op`=1) and multiply-add (`req_op`=2) have a latency of 5 cycles. After one is granted, no pipelined-class request is granted in the next cycle.
- R5: Single-precision divide (`req_op`=3), reciprocal (4) and square root (5) have a latency of 21 cycles. They hold the iterative engine so that the next iterative grant comes no earlier than 19 cycles later.
- R6: Single-precision reciprocal square root (`req_op`=6) has a latency of 38 cycles and an engine occupancy of 36 cycles.
- R7: Double-precision divide, reciprocal and square root have a latency of 36 cycles and an occupancy of 34 cycles. Double-precision reciprocal square root has a latency of 68 cycles and an occupancy of 66 cycles.
- R8: The two resources are independent. A busy iterative engine never stalls a pipelined-class request, and a busy pipelined path never stalls an iterative one.
- R9: Both `req_src_a` and `req_src_b` are checked for every class. A request is stalled when either source names a register whose producer was granted fewer than that producer's latency cycles ago.
- R10: A request is stalled when its latency is not greater than the remaining cycles of an outstanding write to `req_dst`. The remaining cycles equal the older producer's latency minus the cycles elapsed since its grant.
- R11: While `flush` is high, nothing is granted. From the next cycle onward, no earlier grant affects any decision.
- R12: `req_dbl`=1 selects double precision. `req_op` codes are: 0 add, 1 multiply, 2 multiply-add, 3 divide, 4 reciprocal, 5 square root, 6 reciprocal square root. Code 7 is handled exactly as an add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drops all outstanding timing state |
| req_valid | input | 1 | An operation is presented for issue |
| req_op | input | 3 | Operation class code |
| req_dbl | input | 1 | 1 = double precision, 0 = single |
| req_dst | input | REG_W (5) | Destination register number |
| req_src_a | input | REG_W (5) | First source register number |
| req_src_b | input | REG_W (5) | Second source register number |
| issue_grant | output | 1 | Operation starts this cycle |
| issue_stall | output | 1 | Operation presented but held back |

## Verification
The properties assume that register numbers are below the register count, that `flush` is low during the first cycle after reset, and that inputs change only between clock edges. The stimulus drives every input on the falling edge and draws register numbers from a narrow range. This makes read-after-write and write-after-write collisions frequent while staying inside the register file. Flushes are sparse, so long iterative operations have time to run into one another.

// File: rtl/fp_sb_pkg.sv
`timescale 1ns/1ps
package fp_sb_pkg;

    localparam int CNT_W = 7;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_MUL   = 3'd1,
        OP_MADD  = 3'd2,
        OP_DIV   = 3'd3,
        OP_RECIP = 3'd4,
        OP_SQRT  = 3'd5,
        OP_RSQRT = 3'd6,
        OP_ALT   = 3'd7
    } fp_op_e;

    typedef enum logic {
        UNIT_PIPE = 1'b0,
        UNIT_ITER = 1'b1
    } fp_unit_e;

    localparam int NUM_UNITS = 2;

    typedef struct packed {
        fp_unit_e unit;
        cnt_t     lat;
        cnt_t     occ;
    } op_timing_t;

    typedef struct packed {
        logic raw;
        logic waw;
        logic busy;
    } hazard_t;

    localparam cnt_t PIPE_LAT      = cnt_t'(4);
    localparam cnt_t PIPE_OCC      = cnt_t'(1);
    localparam cnt_t DMUL_LAT      = cnt_t'(5);
    localparam cnt_t DMUL_OCC      = cnt_t'(2);
    localparam cnt_t S_DIV_LAT     = cnt_t'(21);
    localparam cnt_t S_DIV_OCC     = cnt_t'(19);
    localparam cnt_t S_RSQ_LAT     = cnt_t'(38);
    localparam cnt_t S_RSQ_OCC     = cnt_t'(36);
    localparam cnt_t D_DIV_LAT     = cnt_t'(36);
    localparam cnt_t D_DIV_OCC     = cnt_t'(34);
    localparam cnt_t D_RSQ_LAT     = cnt_t'(68);
    localparam cnt_t D_RSQ_OCC     = cnt_t'(66);

    function automatic logic op_is_iterative(logic [2:0] code);
        return (code >= 3'd3) && (code <= 3'd6);
    endfunction

    function automatic op_timing_t lookup_timing(fp_op_e op, logic dbl);
        op_timing_t t;
        case (op)
            OP_MUL, OP_MADD: begin
                t.unit = UNIT_PIPE;
                t.lat  = dbl ? DMUL_LAT : PIPE_LAT;
                t.occ  = dbl ? DMUL_OCC : PIPE_OCC;
            end
            OP_DIV, OP_RECIP, OP_SQRT: begin
                t.unit = UNIT_ITER;
                t.lat  = dbl ? D_DIV_LAT : S_DIV_LAT;
                t.occ  = dbl ? D_DIV_OCC : S_DIV_OCC;
            end
            OP_RSQRT: begin
                t.unit = UNIT_ITER;
                t.lat  = dbl ? D_RSQ_LAT : S_RSQ_LAT;
                t.occ  = dbl ? D_RSQ_OCC : S_RSQ_OCC;
            end
            default: begin
                t.unit = UNIT_PIPE;
                t.lat  = PIPE_LAT;
                t.occ  = PIPE_OCC;
            end
        endcase
        return t;
    endfunction

endpackage

// File: rtl/fp_sb_timing.sv
`timescale 1ns/1ps
module fp_sb_timing
    import fp_sb_pkg::*;
(
    input  logic [2:0]  op_code,
    input  logic        dbl,
    output op_timing_t  timing
);

    always_comb begin
        timing = lookup_timing(fp_op_e'(op_code), dbl);
    end

endmodule

// File: rtl/fp_sb_busy_timer.sv
`timescale 1ns/1ps
module fp_sb_busy_timer
    import fp_sb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic load,
    input  cnt_t load_val,
    output logic busy
);

    cnt_t remain_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - cnt_t'(1);
        end
    end

    assign busy = (remain_q != '0);

endmodule

// File: rtl/fp_sb_reg_track.sv
`timescale 1ns/1ps
module fp_sb_reg_track
    import fp_sb_pkg::*;
#(
    parameter  int NUM_REGS = 32,
    localparam int REG_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_idx,
    input  cnt_t             wr_val,
    input  logic [REG_W-1:0] rd_a_idx,
    input  logic [REG_W-1:0] rd_b_idx,
    input  logic [REG_W-1:0] dst_idx,
    output logic             pend_a,
    output logic             pend_b,
    output cnt_t             dst_remain
);

    cnt_t ready_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                ready_q[g] <= '0;
            end else if (wr_en && (wr_idx == REG_W'(g))) begin
                ready_q[g] <= wr_val;
            end else if (ready_q[g] != '0) begin
                ready_q[g] <= ready_q[g] - cnt_t'(1);
            end
        end
    end

    assign pend_a     = (ready_q[rd_a_idx] != '0);
    assign pend_b     = (ready_q[rd_b_idx] != '0);
    assign dst_remain = ready_q[dst_idx];

endmodule

// File: rtl/fp_issue_scoreboard.sv
`timescale 1ns/1ps
module fp_issue_scoreboard
    import fp_sb_pkg::*;
#(
    parameter  int NUM_REGS = 32,
    localparam int REG_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    input  logic             req_dbl,
    input  logic [REG_W-1:0] req_dst,
    input  logic [REG_W-1:0] req_src_a,
    input  logic [REG_W-1:0] req_src_b,
    output logic             issue_grant,
    output logic             issue_stall
);

    op_timing_t           tm;
    hazard_t              hz;
    logic                 pend_a;
    logic                 pend_b;
    cnt_t                 dst_remain;
    logic [NUM_UNITS-1:0] unit_busy;

    fp_sb_timing u_timing (
        .op_code (req_op),
        .dbl     (req_dbl),
        .timing  (tm)
    );

    fp_sb_reg_track #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .wr_en      (issue_grant),
        .wr_idx     (req_dst),
        .wr_val     (tm.lat - cnt_t'(1)),
        .rd_a_idx   (req_src_a),
        .rd_b_idx   (req_src_b),
        .dst_idx    (req_dst),
        .pend_a     (pend_a),
        .pend_b     (pend_b),
        .dst_remain (dst_remain)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        fp_sb_busy_timer u_timer (
            .clk      (clk),
            .rst      (rst),
            .flush    (flush),
            .load     (issue_grant && (tm.unit == fp_unit_e'(u))),
            .load_val (tm.occ - cnt_t'(1)),
            .busy     (unit_busy[u])
        );
    end

    always_comb begin
        hz.raw  = pend_a || pend_b;
        hz.waw  = (tm.lat <= dst_remain);
        hz.busy = unit_busy[tm.unit];
    end

    assign issue_grant = req_valid && !flush && !(hz.raw || hz.waw || hz.busy);
    assign issue_stall = req_valid && !issue_grant;

endmodule

// File: rtl/fp_issue_scoreboard_chk.sv
`timescale 1ns/1ps
module fp_issue_scoreboard_chk
    import fp_sb_pkg::*;
#(
    parameter  int NUM_REGS = 32,
    localparam int REG_W    = $clog2(NUM_REGS)
) (
    input logic             clk,
    input logic             rst,
    input logic             flush,
    input logic             req_valid,
    input logic [2:0]       req_op,
    input logic             req_dbl,
    input logic [REG_W-1:0] req_dst,
    input logic [REG_W-1:0] req_src_a,
    input logic [REG_W-1:0] req_src_b,
    input logic             issue_grant,
    input logic             issue_stall
);

    AST_GRANT_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        issue_grant |-> (req_valid && !flush)); // R2

    AST_GRANT_STALL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(issue_grant && issue_stall)); // R2

    AST_POST_RESET_GRANT: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && req_valid && !flush) |-> issue_grant); // R1

    AST_DMUL_PIPE_GAP: assert property (@(posedge clk) disable iff (rst)
        (issue_grant && req_dbl && (req_op == 3'd1 || req_op == 3'd2))
        |=> !(issue_grant && !op_is_iterative(req_op))); // R4

    AST_ITER_NO_BACK2BACK: assert property (@(posedge clk) disable iff (rst)
        (issue_grant && op_is_iterative(req_op))
        |=> !(issue_grant && op_is_iterative(req_op))); // R5

    AST_RAW_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        issue_grant |=> !(issue_grant &&
            (req_src_a == $past(req_dst) || req_src_b == $past(req_dst)))); // R9

    AST_FLUSH_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ($past(flush) && !flush && req_valid) |-> issue_grant); // R11

endmodule

bind fp_issue_scoreboard fp_issue_scoreboard_chk #(.NUM_REGS(NUM_REGS)) u_chk (.*);

// File: tb/fp_issue_scoreboard_bench.sv
`timescale 1ns/1ps
module fp_issue_scoreboard_bench;

    localparam int NUM_REGS = 32;
    localparam int REG_W    = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             flush = 1'b0;
    logic             req_valid = 1'b0;
    logic [2:0]       req_op = 3'd0;
    logic             req_dbl = 1'b0;
    logic [REG_W-1:0] req_dst = '0;
    logic [REG_W-1:0] req_src_a = '0;
    logic [REG_W-1:0] req_src_b = '0;
    logic             issue_grant;
    logic             issue_stall;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    bit last_exp = 0;

    int m_reg [NUM_REGS];
    int m_pipe = 0;
    int m_iter = 0;

    always #2.5 clk = ~clk;

    fp_issue_scoreboard #(.NUM_REGS(NUM_REGS)) u_fp_issue_scoreboard (
        .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid),
        .req_op(req_op), .req_dbl(req_dbl), .req_dst(req_dst),
        .req_src_a(req_src_a), .req_src_b(req_src_b),
        .issue_grant(issue_grant), .issue_stall(issue_stall)
    );

    // Expected timing from R3..R7 and R12
    function automatic void ref_timing(input int op, input bit dbl,
                                       output int lat, output int occ, output bit iter);
        iter = 0; lat = 4; occ = 1;
        if (op == 1 || op == 2) begin
            lat = dbl ? 5 : 4; occ = dbl ? 2 : 1;
        end else if (op >= 3 && op <= 5) begin
            iter = 1; lat = dbl ? 36 : 21; occ = dbl ? 34 : 19;
        end else if (op == 6) begin
            iter = 1; lat = dbl ? 68 : 38; occ = dbl ? 66 : 36;
        end
    endfunction

    task automatic model_clear();
        for (int i = 0; i < NUM_REGS; i++) m_reg[i] = 0;
        m_pipe = 0; m_iter = 0;
    endtask

    task automatic check(input string tag, input bit got, input bit exp, input string what);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic step(input bit v, input int op, input bit dbl, input int dst,
                        input int a, input int b, input bit fl, input string tag);
        int lat, occ; bit iter, hz, exp;
        @(negedge clk);
        req_valid = v; req_op = 3'(op); req_dbl = dbl; req_dst = REG_W'(dst);
        req_src_a = REG_W'(a); req_src_b = REG_W'(b); flush = fl;
        #1;
        ref_timing(op, dbl, lat, occ, iter);
        hz = (m_reg[a] != 0) || (m_reg[b] != 0) || (lat <= m_reg[dst]) ||
             (iter ? (m_iter != 0) : (m_pipe != 0));
        exp = v && !fl && !hz;
        last_exp = exp;
        check(tag, issue_grant, exp, "grant");
        check("R2", issue_stall, v && !exp, "stall");
        @(posedge clk);
        if (fl) begin
            model_clear();
        end else begin
            for (int i = 0; i < NUM_REGS; i++) if (m_reg[i] > 0) m_reg[i]--;
            if (m_pipe > 0) m_pipe--;
            if (m_iter > 0) m_iter--;
            if (exp) begin
                m_reg[dst] = lat - 1;
                if (iter) m_iter = occ - 1; else m_pipe = occ - 1;
            end
        end
    endtask

    // Present the same request until it is granted (bounded)
    task automatic hold(input int op, input bit dbl, input int dst, input int a,
                        input int b, input string tag);
        for (int n = 0; n < 80; n++) begin
            step(1, op, dbl, dst, a, b, 0, tag);
            if (last_exp) break;
        end
    endtask

    task automatic do_flush();
        step(1, 0, 0, 20, 21, 22, 1, "R11");
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed = 32'h5eed_0fa1;
        void'($urandom(seed));
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R1", issue_grant, 1'b0, "grant in reset");
        check("R1", issue_stall, 1'b0, "stall in reset");
        rst = 1'b0;

        // R1: first request after reset granted
        step(1, 6, 1, 1, 1, 1, 0, "R1");
        do_flush();
        // R3: back-to-back pipelined grants, including DP add
        step(1, 0, 0, 4, 2, 3, 0, "R3");
        step(1, 1, 0, 5, 2, 3, 0, "R3");
        step(1, 0, 1, 6, 2, 3, 0, "R3");
        // R9: consumer of r4 waits for 4-cycle latency
        hold(0, 0, 7, 9, 4, "R9");
        // R4: DP multiply then add blocked one cycle; consumer waits 5
        step(1, 2, 1, 8, 2, 3, 0, "R4");
        step(1, 0, 0, 9, 2, 3, 0, "R4");
        step(1, 0, 0, 9, 2, 3, 0, "R4");
        hold(1, 0, 10, 8, 2, "R4");
        // R5: SP divide then second iterative op stalls 19 cycles
        step(1, 3, 0, 11, 2, 3, 0, "R5");
        step(1, 0, 0, 12, 2, 3, 0, "R8");
        hold(5, 0, 13, 2, 3, "R5");
        // R6: SP rsqrt occupancy
        hold(6, 0, 14, 2, 3, "R6");
        step(1, 1, 1, 15, 2, 3, 0, "R8");
        hold(4, 0, 16, 2, 3, "R6");
        // R7: DP divide and DP rsqrt
        hold(3, 1, 17, 2, 3, "R7");
        hold(6, 1, 18, 2, 3, "R7");
        hold(0, 0, 19, 18, 2, "R7");
        // R10: write-after-write against a long producer
        do_flush();
        step(1, 6, 0, 24, 2, 3, 0, "R10");
        step(1, 0, 0, 24, 2, 3, 0, "R10");
        step(1, 0, 1, 24, 2, 3, 0, "R10");
        do_flush();
        step(1, 0, 0, 24, 24, 24, 0, "R11");
        // R12: code 7 behaves as an add
        step(1, 7, 1, 25, 2, 3, 0, "R12");
        step(1, 7, 0, 26, 2, 3, 0, "R12");
        hold(0, 0, 27, 25, 3, "R12");

        // Constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            int op, r;
            bit v, fl, d;
            r  = int'($urandom_range(0, 9));
            op = (r < 5) ? int'($urandom_range(0, 2)) : int'($urandom_range(0, 7));
            v  = ($urandom_range(0, 7) != 0);
            fl = ($urandom_range(0, 199) == 0);
            d  = $urandom_range(0, 1) != 0;
            step(v, op, d, int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                 int'($urandom_range(0, 7)), fl, fl ? "R11" : "R2");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule